// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block decides which received CAN frames reach the host. Each completed frame comes in as one cycle pulse that carries its four identifier bytes and its payload. The frame is always written into a background slot. Its identifier is then compared bit by bit against four acceptance bytes, and four mask bytes mark which bits do not matter. A frame that passes while the host buffer is empty is promoted: the background and foreground slots trade places and a sticky receive-full flag rises. A frame that fails stays in the background slot, and the next arrival writes over it.

The frame format comes from the identifier-extension bit inside the identifier bytes. Extended frames are compared on all four bytes. Standard frames are compared on the first two bytes only. A small register port holds the acceptance and mask bytes. It can always be read. It takes writes only while the host requests initialization and the controller acknowledges it.

Top module: `can_id_filter`

## Requirements
- R1: After reset every acceptance and mask byte reads 0 and `rx_full` is 0.
- R2: While `init_req` and `init_ack` are both 1, a `cfg_wr` pulse stores `cfg_wdata` into the byte chosen by `cfg_addr`. `cfg_addr[2]`=0 selects an acceptance byte and 1 selects a mask byte. `cfg_addr[1:0]`=n selects byte n. Byte n lines up with `frm_id[31-8n -: 8]`, so byte 0 is the most significant. `cfg_rdata` shows the byte at `cfg_raddr` in the same cycle.
- R3: A `cfg_wr` made while `init_req` or `init_ack` is 0 is ignored, and every stored byte keeps its value.
- R4: A mask bit of 1 makes that identifier bit don't-care. A mask bit of 0 requires the received bit to equal the acceptance bit. A frame passes only when every bit that takes part matches.
- R5: The format bit is `frm_id[19]` (bit 3 of byte 1). When it is 1, all 32 bits take part. When it is 0, only bits 31:16 (bytes 0 and 1) take part, and bytes 2 and 3 have no effect.
- R6: A passing frame that arrives while `rx_full` is 0 appears on `fg_id`/`fg_data`, with `rx_full` at 1, after the next clock edge.
- R7: A failing frame leaves `rx_full`, `fg_id` and `fg_data` unchanged. A later passing frame replaces it, and only the later frame reaches the foreground.
- R8: While `rx_full` is 1, no frame is promoted, whether it passes or not, and the foreground is held.
- R9: A `rx_clr` pulse clears `rx_full` at the next edge. When a clear and a passing frame arrive in the same cycle while `rx_full` is 1, the flag clears and that frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Host requests initialization mode |
| init_ack | input | 1 | Controller acknowledges initialization mode |
| cfg_wr | input | 1 | Write strobe for a filter byte |
| cfg_addr | input | 3 | Write address: bit 2 picks mask, bits 1:0 pick the byte |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 3 | Read address, same map as the write address |
| cfg_rdata | output | 8 | Filter byte at the read address |
| frm_valid | input | 1 | One-cycle pulse: a completed frame is present |
| frm_id | input | 32 | Identifier bytes 0..3, with byte 0 in bits 31:24 |
| frm_data | input | DATA_W | Frame payload |
| rx_clr | input | 1 | Clears the receive-full flag |
| rx_full | output | 1 | Sticky flag: a frame waits for the host |
| fg_id | output | 32 | Identifier of the foreground frame |
| fg_data | output | DATA_W | Payload of the foreground frame |

## Verification
Two cases are hard to reach from the ports. One is a clear and a passing frame in the very same cycle while the flag is set. The other is a rejected frame that has to be shown overwritten even though no port shows the background slot. The bench drives both inputs on one falling edge to produce the collision. It then sends a failing frame and after it a passing one, and checks that only the second reaches the foreground. Per-bit filter behaviour is swept by flipping each identifier bit in turn, for both formats and several mask patterns, against a bit-loop model in the bench.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int ID_BYTES = 4;
  localparam int ID_W     = ID_BYTES * 8;
  localparam int FMT_BIT  = 19;          // bit 3 of identifier byte 1
  localparam int STD_BYTES = 2;
  localparam int STD_LSB  = ID_W - STD_BYTES * 8;

  // Bits that take part in the comparison for the given frame.
  function automatic logic [ID_W-1:0] care_bits(input logic [ID_W-1:0] id,
                                                 input logic [ID_W-1:0] msk);
    logic [ID_W-1:0] span;
    span = '1;
    if (!id[FMT_BIT]) span[STD_LSB-1:0] = '0;
    return span & ~msk;
  endfunction

  function automatic logic id_pass(input logic [ID_W-1:0] id,
                                   input logic [ID_W-1:0] acc,
                                   input logic [ID_W-1:0] msk);
    return ((id ^ acc) & care_bits(id, msk)) == '0;
  endfunction
endpackage

// File: rtl/flt_regs.sv
module flt_regs
  import can_flt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_req,
  input  logic            init_ack,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic [2:0]      cfg_raddr,
  output logic [7:0]      cfg_rdata,
  output logic [ID_W-1:0] acc_vec,
  output logic [ID_W-1:0] msk_vec
);
  logic       init_mode;
  logic       wr_ok;
  logic [7:0] acc_q [ID_BYTES];
  logic [7:0] msk_q [ID_BYTES];

  assign init_mode = init_req && init_ack;
  assign wr_ok     = cfg_wr && init_mode;

  for (genvar b = 0; b < ID_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[b] <= '0;
        msk_q[b] <= '0;
      end else if (wr_ok && cfg_addr[1:0] == 2'(b)) begin
        if (cfg_addr[2]) msk_q[b] <= cfg_wdata;
        else             acc_q[b] <= cfg_wdata;
      end
    end
    assign acc_vec[ID_W-1-8*b -: 8] = acc_q[b];
    assign msk_vec[ID_W-1-8*b -: 8] = msk_q[b];
  end

  assign cfg_rdata = cfg_raddr[2] ? msk_q[cfg_raddr[1:0]] : acc_q[cfg_raddr[1:0]];

  // R3: nothing moves outside initialization mode
  a_r3_locked_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_mode |=> ($stable(acc_vec) && $stable(msk_vec)));
  // R2: a granted write lands in the addressed acceptance byte
  a_r2_acc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !cfg_addr[2]) |=>
      acc_vec[ID_W-1-8*$past(cfg_addr[1:0]) -: 8] == $past(cfg_wdata));
endmodule

// File: rtl/flt_match.sv
module flt_match
  import can_flt_pkg::*;
(
  input  logic [ID_W-1:0] frm_id,
  input  logic [ID_W-1:0] acc_vec,
  input  logic [ID_W-1:0] msk_vec,
  output logic            frm_hit
);
  assign frm_hit = id_pass(frm_id, acc_vec, msk_vec);

  // R5: standard frames do not depend on the low two bytes of the filter
  always_comb begin
    if (!frm_id[FMT_BIT])
      a_r5_std_low_ignored: assert (frm_hit == id_pass(frm_id,
        {acc_vec[ID_W-1:STD_LSB], ~acc_vec[STD_LSB-1:0]},
        {msk_vec[ID_W-1:STD_LSB], ~msk_vec[STD_LSB-1:0]}));
  end
endmodule

// File: rtl/rx_bufs.sv
module rx_bufs
  import can_flt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_hit,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              rx_clr,
  output logic              rx_full,
  output logic [ID_W-1:0]   fg_id,
  output logic [DATA_W-1:0] fg_data
);
  localparam int SLOTS = 2;

  logic              fg_sel;
  logic              promote;
  logic [ID_W-1:0]   slot_id   [SLOTS];
  logic [DATA_W-1:0] slot_data [SLOTS];

  assign promote = frm_valid && frm_hit && !rx_full;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_id[s]   <= '0;
        slot_data[s] <= '0;
      end else if (frm_valid && fg_sel != 1'(s)) begin
        slot_id[s]   <= frm_id;
        slot_data[s] <= frm_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_sel  <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      if (promote) fg_sel <= ~fg_sel;
      if (promote)     rx_full <= 1'b1;
      else if (rx_clr) rx_full <= 1'b0;
    end
  end

  assign fg_id   = slot_id[fg_sel];
  assign fg_data = slot_data[fg_sel];

  // R6: a promoted frame is what the host sees next
  a_r6_promote_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_hit && !rx_full) |=> (rx_full && fg_id == $past(frm_id)));
  // R7: a rejected frame disturbs nothing the host sees
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_hit && !rx_clr) |=>
      ($stable(rx_full) && $stable(fg_id) && $stable(fg_data)));
  // R8: foreground is frozen while full
  a_r8_fg_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> ($stable(fg_id) && $stable(fg_data)));
  // R9: a clear on a full buffer always empties it
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && rx_full) |=> !rx_full);
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_flt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [7:0]        cfg_rdata,
  input  logic              frm_valid,
  input  logic [31:0]       frm_id,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              rx_clr,
  output logic              rx_full,
  output logic [31:0]       fg_id,
  output logic [DATA_W-1:0] fg_data
);
  logic [ID_W-1:0] acc_vec;
  logic [ID_W-1:0] msk_vec;
  logic            frm_hit;

  flt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .acc_vec(acc_vec), .msk_vec(msk_vec)
  );

  flt_match u_match (
    .frm_id(frm_id), .acc_vec(acc_vec), .msk_vec(msk_vec), .frm_hit(frm_hit)
  );

  rx_bufs #(.DATA_W(DATA_W)) u_bufs (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_hit(frm_hit),
    .frm_id(frm_id), .frm_data(frm_data), .rx_clr(rx_clr),
    .rx_full(rx_full), .fg_id(fg_id), .fg_data(fg_data)
  );

  // R4: with every mask bit set, any frame passes
  a_r4_all_masked_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_vec == '1) |-> frm_hit);
endmodule

// File: tb/tb_can_id_filter.sv
`timescale 1ns/1ps
module tb_can_id_filter;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, init_ack = 1'b0, cfg_wr = 1'b0, frm_valid = 1'b0, rx_clr = 1'b0;
  logic [2:0] cfg_addr = '0, cfg_raddr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [31:0] frm_id = '0;
  logic [DW-1:0] frm_data = '0;
  logic rx_full;
  logic [31:0] fg_id;
  logic [DW-1:0] fg_data;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [31:0] exp_id;
  logic [DW-1:0] exp_data;
  bit exp_full;
  logic [31:0] acc_cfg, msk_cfg;

  always #4 clk = ~clk;

  can_id_filter #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .frm_valid(frm_valid),
    .frm_id(frm_id), .frm_data(frm_data), .rx_clr(rx_clr),
    .rx_full(rx_full), .fg_id(fg_id), .fg_data(fg_data)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-by-bit reference: byte n sits in bits 31-8n..24-8n; format bit is 19.
  function automatic bit model_pass(logic [31:0] id, logic [31:0] acc, logic [31:0] msk);
    bit ext = id[19];
    for (int b = 0; b < 32; b++) begin
      int byte_no = 3 - b / 8;
      if (!ext && byte_no >= 2) continue;
      if (!msk[b] && id[b] != acc[b]) return 0;
    end
    return 1;
  endfunction

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
    cfg_raddr = a; #1; d = cfg_rdata;
  endtask

  task automatic load_filter(input logic [31:0] acc, input logic [31:0] msk);
    init_req = 1; init_ack = 1;
    for (int n = 0; n < 4; n++) begin
      wr_byte(3'(n), acc[31-8*n -: 8]);
      wr_byte(3'(4+n), msk[31-8*n -: 8]);
    end
    init_req = 0; init_ack = 0;
    acc_cfg = acc; msk_cfg = msk;
  endtask

  task automatic send(input logic [31:0] id, input logic [DW-1:0] d, input bit clr);
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_data = d; rx_clr = clr;
    if (!exp_full && model_pass(id, acc_cfg, msk_cfg)) begin
      exp_full = 1; exp_id = id; exp_data = d;
    end else if (clr) exp_full = 0;
    @(negedge clk);
    frm_valid = 0; rx_clr = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    rx_clr = 1;
    @(negedge clk);
    rx_clr = 0;
    exp_full = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    exp_full = 0; exp_id = '0; exp_data = '0; acc_cfg = '0; msk_cfg = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd_byte(3'(a), rb);
      chk("R1 byte", DW'(rb), DW'(0));
    end
    chk("R1 rx_full", DW'(rx_full), DW'(0));
    rst_n = 1;
    @(negedge clk);

    // R2: write and read back, byte order and bank select
    load_filter(32'hA5C3_3C5A, 32'h1122_3344);
    for (int n = 0; n < 4; n++) begin
      rd_byte(3'(n), rb);   chk("R2 acc", DW'(rb), DW'(acc_cfg[31-8*n -: 8]));
      rd_byte(3'(4+n), rb); chk("R2 msk", DW'(rb), DW'(msk_cfg[31-8*n -: 8]));
    end

    // R3: writes without full handshake are ignored
    init_req = 1; init_ack = 0; wr_byte(3'd0, 8'h00);
    init_req = 0; init_ack = 1; wr_byte(3'd5, 8'hFF);
    init_req = 0; init_ack = 0; wr_byte(3'd3, 8'h00);
    init_ack = 0;
    rd_byte(3'd0, rb); chk("R3 acc0", DW'(rb), DW'(8'hA5));
    rd_byte(3'd5, rb); chk("R3 msk1", DW'(rb), DW'(8'h22));
    rd_byte(3'd3, rb); chk("R3 acc3", DW'(rb), DW'(8'h5A));

    // R4/R5/R6: per-bit sweep over formats and mask patterns
    for (int p = 0; p < 3; p++) begin
      logic [31:0] m;
      m = (p == 0) ? 32'h0 : (p == 1) ? 32'h0000_FFFF : 32'hF0F0_0F0F;
      load_filter(32'hA5C3_3C5A, m);
      for (int f = 0; f < 2; f++) begin
        for (int i = 0; i <= 32; i++) begin
          logic [31:0] id;
          id = acc_cfg;
          id[19] = f[0];
          if (i < 32) id[i] = ~id[i];
          send(id, {id, ~id}, 0);
          chk("R4 R5 R6 rx_full", DW'(rx_full), DW'(exp_full));
          chk("R4 R5 R6 fg_id", DW'(fg_id), DW'(exp_id));
          chk("R6 fg_data", fg_data, exp_data);
          if (exp_full) clear_flag();
          chk("R9 cleared", DW'(rx_full), DW'(0));
        end
      end
    end

    // R7: rejected frame is overwritten by the next passing one
    load_filter(32'h1234_5678, 32'h0);
    send(32'h9999_9999, 64'hDEAD, 0);
    chk("R7 reject flag", DW'(rx_full), DW'(0));
    chk("R7 reject fg", DW'(fg_id), DW'(exp_id));
    send(32'h1234_5678, 64'hBEEF, 0);
    chk("R7 later frame", fg_data, DW'(64'hBEEF));
    chk("R7 later id", DW'(fg_id), DW'(32'h1234_5678));

    // R8: full buffer holds its frame against a passing one
    send(32'h1234_5678, 64'hCAFE, 0);
    chk("R8 held data", fg_data, DW'(64'hBEEF));
    chk("R8 still full", DW'(rx_full), DW'(1));

    // R9: clear and passing frame together while full: flag drops, frame lost
    send(32'h1234_5678, 64'hF00D, 1);
    chk("R9 collide flag", DW'(rx_full), DW'(0));
    chk("R9 collide data", fg_data, DW'(64'hBEEF));
    send(32'h1234_5678, 64'h7777, 0);
    chk("R9 after clear", fg_data, DW'(64'h7777));
    chk("R9 after clear flag", DW'(rx_full), DW'(1));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule